// File: doc/BRIEF.md
# Byte Dot-Product Tile Accumulator

This block updates an accumulator tile C in place with the product of two byte tiles, C += A × B. A holds M rows of K bytes. B is stored as K/4 rows, each holding N groups of four bytes. C holds M rows of N 32-bit words. Each 32-bit element of C receives the sum of four byte products per group. Each of the two sources can be read as signed or unsigned bytes, which gives four operand modes.

The tiles live in storage outside the block. The block drives three index outputs (row, column, group) and reads back one 32-bit word of A, one word of B and one accumulator word in the same cycle. Updated accumulator words leave through a write strobe that uses the current row and column indices.

A start pulse latches the shape and the mode. The block then walks the rows in order, the columns within each row, and the K/4 groups within each element, spending one clock on each group. The result is summed modulo 2^32 and never saturates. When a shape is illegal, the block rejects the start and writes nothing.

Top module: `tile_dot_acc`

## Requirements
- R1: With mode = 3, both bytes of every pair are sign-extended before they are multiplied. Byte i of aWord (bits 8i+7:8i) pairs with byte i of bWord.
- R2: Bit 1 of mode selects signed A bytes and bit 0 selects signed B bytes. Mode 0 is unsigned×unsigned, 1 is unsigned A × signed B, and 2 is signed A × unsigned B. A cleared bit zero-extends the byte.
- R3: Each written element equals its previous accumulator value plus the sum of the K byte products, taken modulo 2^32 with no saturation.
- R4: Each element takes K/4 consecutive clocks, one group per clock. The element is written (cWrEn high) in its last group's cycle. Elements follow row-major order: row outer, column inner. A operation with shape M, N, K writes exactly M·N words. While a group is processed, grpIdx indexes both the A word (bytes 4g..4g+3 of row rowIdx) and the B row.
- R5: busy rises the cycle after an accepted start. done is a single-cycle pulse in the cycle after the last write, and busy is low in that same cycle. The gap from the start edge to done is M·N·K/4 cycles.
- R6: A start is rejected when K is zero or not a multiple of 4, when M or N is zero, or when M > MAX_ROWS, N > ROW_BYTES/4, K > ROW_BYTES or K/4 > MAX_ROWS. A rejected start raises err for one cycle, leaves busy low and causes no write.
- R7: A start pulse while busy is ignored. The running operation keeps its shape, order and length.
- R8: After reset, busy, done, err and cWrEn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the shape and mode presented |
| mode | input | 2 | Bit 1: A signed; bit 0: B signed |
| dimM | input | 5 | Rows of A and C |
| dimN | input | 5 | 32-bit columns of C (groups per B row) |
| dimK | input | 7 | Bytes per A row |
| rowIdx | output | 4 | Current row of A and C |
| colIdx | output | 4 | Current column of C and group column of B |
| grpIdx | output | 4 | Current group: A word in the row, and B row |
| aWord | input | 32 | Four A bytes at rowIdx, grpIdx |
| bWord | input | 32 | Four B bytes at grpIdx, colIdx |
| cRdData | input | 32 | Accumulator word at rowIdx, colIdx |
| cWrEn | output | 1 | Write the updated accumulator word |
| cWrData | output | 32 | Updated accumulator word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejected-start pulse |

## Verification
Two situations are hard to reach from the ports. The first is a 32-bit wraparound within a single element. The stimulus forces it by placing 0x7FFFFFFF or 0xFFFFFFFF in an accumulator word and then feeding extreme bytes (0x7F, 0x80, 0xFF) in each mode. The second is a start pulse that arrives mid-run. The bench raises start a few cycles into a full operation, with a different shape, and confirms that the queued element sequence and the done cycle still match the original shape. Single-group elements (K = 4) are also covered, because the accumulator word is read and written in the same cycle there.

// File: rtl/tile_dot_pkg.sv
package tile_dot_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int ACC_W  = 32;
  localparam int WORD_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    MODE_UU = 2'd0,
    MODE_US = 2'd1,
    MODE_SU = 2'd2,
    MODE_SS = 2'd3
  } dotMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stepEn;
    logic firstGrp;
    logic lastGrp;
    logic aSigned;
    logic bSigned;
  } dotStrobe_t;
endpackage

// File: rtl/tile_dot_ctrl.sv
module tile_dot_ctrl
  import tile_dot_pkg::*;
#(
  parameter int MAX_ROWS  = 16,
  parameter int ROW_BYTES = 64,
  localparam int COLS  = ROW_BYTES / LANES,
  localparam int ROW_W = $clog2(MAX_ROWS),
  localparam int GRP_W = $clog2(COLS),
  localparam int M_W   = ROW_W + 1,
  localparam int N_W   = GRP_W + 1,
  localparam int K_W   = $clog2(ROW_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [M_W-1:0]   dimM,
  input  logic [N_W-1:0]   dimN,
  input  logic [K_W-1:0]   dimK,
  output dotStrobe_t       stb,
  output logic [ROW_W-1:0] rowIdx,
  output logic [GRP_W-1:0] colIdx,
  output logic [GRP_W-1:0] grpIdx,
  output logic             busy,
  output logic             done,
  output logic             err
);
  logic [ROW_W-1:0] rowR, rowLast;
  logic [GRP_W-1:0] colR, colLast, grpR, grpLast;
  logic [K_W-3:0]   kGroups;
  dotMode_t         modeR;
  logic             cfgOk, lastGrp, lastCol, lastRow;

  assign kGroups = dimK[K_W-1:2];

  always_comb begin
    cfgOk = (dimM != '0) && (int'(dimM) <= MAX_ROWS) &&
            (dimN != '0) && (int'(dimN) <= COLS) &&
            (dimK[1:0] == 2'b00) && (dimK != '0) &&
            (int'(dimK) <= ROW_BYTES) && (int'(kGroups) <= MAX_ROWS);
  end

  assign lastGrp = (grpR == grpLast);
  assign lastCol = (colR == colLast);
  assign lastRow = (rowR == rowLast);

  always_comb begin
    stb.stepEn   = busy;
    stb.firstGrp = (grpR == '0);
    stb.lastGrp  = lastGrp;
    stb.aSigned  = (modeR == MODE_SS) || (modeR == MODE_SU);
    stb.bSigned  = (modeR == MODE_SS) || (modeR == MODE_US);
  end

  assign rowIdx = rowR;
  assign colIdx = colR;
  assign grpIdx = grpR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rowR    <= '0;
      colR    <= '0;
      grpR    <= '0;
      rowLast <= '0;
      colLast <= '0;
      grpLast <= '0;
      modeR   <= MODE_UU;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (cfgOk) begin
            busy    <= 1'b1;
            rowR    <= '0;
            colR    <= '0;
            grpR    <= '0;
            rowLast <= ROW_W'(dimM - M_W'(1));
            colLast <= GRP_W'(dimN - N_W'(1));
            grpLast <= GRP_W'(kGroups - (K_W-2)'(1));
            modeR   <= dotMode_t'(mode);
          end else begin
            err <= 1'b1;
          end
        end
      end else if (!lastGrp) begin
        grpR <= grpR + GRP_W'(1);
      end else begin
        grpR <= '0;
        if (!lastCol) begin
          colR <= colR + GRP_W'(1);
        end else begin
          colR <= '0;
          if (!lastRow) begin
            rowR <= rowR + ROW_W'(1);
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tile_dot_path.sv
module tile_dot_path
  import tile_dot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dotStrobe_t        stb,
  input  logic [WORD_W-1:0] aWord,
  input  logic [WORD_W-1:0] bWord,
  input  logic [ACC_W-1:0]  cRdData,
  output logic [ACC_W-1:0]  accNext
);
  localparam int PROD_W = 2 * BYTE_W + 2;

  logic [ACC_W-1:0] accR;
  logic [ACC_W-1:0] laneTerm [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0]        aByte, bByte;
    logic signed [BYTE_W:0]   aExt, bExt;
    logic signed [PROD_W-1:0] prod;

    assign aByte = aWord[i*BYTE_W +: BYTE_W];
    assign bByte = bWord[i*BYTE_W +: BYTE_W];
    assign aExt  = {stb.aSigned & aByte[BYTE_W-1], aByte};
    assign bExt  = {stb.bSigned & bByte[BYTE_W-1], bByte};
    assign prod  = aExt * bExt;
    assign laneTerm[i] = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  always_comb begin
    accNext = stb.firstGrp ? cRdData : accR;
    for (int i = 0; i < LANES; i++) begin
      accNext = accNext + laneTerm[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR <= '0;
    end else if (stb.stepEn) begin
      accR <= accNext;
    end
  end
endmodule

// File: rtl/tile_dot_acc.sv
module tile_dot_acc
  import tile_dot_pkg::*;
#(
  parameter int MAX_ROWS  = 16,
  parameter int ROW_BYTES = 64,
  localparam int COLS  = ROW_BYTES / LANES,
  localparam int ROW_W = $clog2(MAX_ROWS),
  localparam int GRP_W = $clog2(COLS),
  localparam int M_W   = ROW_W + 1,
  localparam int N_W   = GRP_W + 1,
  localparam int K_W   = $clog2(ROW_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [M_W-1:0]    dimM,
  input  logic [N_W-1:0]    dimN,
  input  logic [K_W-1:0]    dimK,
  output logic [ROW_W-1:0]  rowIdx,
  output logic [GRP_W-1:0]  colIdx,
  output logic [GRP_W-1:0]  grpIdx,
  input  logic [WORD_W-1:0] aWord,
  input  logic [WORD_W-1:0] bWord,
  input  logic [ACC_W-1:0]  cRdData,
  output logic              cWrEn,
  output logic [ACC_W-1:0]  cWrData,
  output logic              busy,
  output logic              done,
  output logic              err
);
  dotStrobe_t stb;

  tile_dot_ctrl #(.MAX_ROWS(MAX_ROWS), .ROW_BYTES(ROW_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .dimM(dimM), .dimN(dimN), .dimK(dimK), .stb(stb),
    .rowIdx(rowIdx), .colIdx(colIdx), .grpIdx(grpIdx),
    .busy(busy), .done(done), .err(err)
  );

  tile_dot_path u_path (
    .clk(clk), .rstN(rstN), .stb(stb),
    .aWord(aWord), .bWord(bWord), .cRdData(cRdData),
    .accNext(cWrData)
  );

  assign cWrEn = stb.stepEn & stb.lastGrp;
endmodule

// File: rtl/tile_dot_acc_chk.sv
module tile_dot_acc_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic err,
  input logic cWrEn
);
  assert_write_when_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    cWrEn |-> busy);

  assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!busy && !cWrEn && !done));
endmodule

bind tile_dot_acc tile_dot_acc_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err), .cWrEn(cWrEn)
);

// File: tb/sim_tile_dot_acc.sv
module sim_tile_dot_acc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [4:0] dimM = '0;
  logic [4:0] dimN = '0;
  logic [6:0] dimK = '0;
  logic [3:0] rowIdx, colIdx, grpIdx;
  logic [31:0] aWord, bWord, cRdData, cWrData;
  logic cWrEn, busy, done, err;

  logic [7:0]  aMem [16][64];
  logic [7:0]  bMem [16][64];
  logic [31:0] cMem [16][16];

  typedef struct {
    int row;
    int col;
    logic [31:0] value;
    string req;
  } item_t;
  item_t expQ[$];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_dot_acc u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .dimM(dimM), .dimN(dimN), .dimK(dimK),
    .rowIdx(rowIdx), .colIdx(colIdx), .grpIdx(grpIdx),
    .aWord(aWord), .bWord(bWord), .cRdData(cRdData),
    .cWrEn(cWrEn), .cWrData(cWrData),
    .busy(busy), .done(done), .err(err)
  );

  assign aWord = {aMem[rowIdx][4*grpIdx+3], aMem[rowIdx][4*grpIdx+2],
                  aMem[rowIdx][4*grpIdx+1], aMem[rowIdx][4*grpIdx]};
  assign bWord = {bMem[grpIdx][4*colIdx+3], bMem[grpIdx][4*colIdx+2],
                  bMem[grpIdx][4*colIdx+1], bMem[grpIdx][4*colIdx]};
  assign cRdData = cMem[rowIdx][colIdx];

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refElem(int m, int n, int k, logic [1:0] md);
    logic [31:0] s;
    s = cMem[m][n];
    for (int i = 0; i < k; i++) begin
      int av, bv;
      av = md[1] ? int'($signed(aMem[m][i])) : int'(aMem[m][i]);
      bv = md[0] ? int'($signed(bMem[i/4][n*4+i%4])) : int'(bMem[i/4][n*4+i%4]);
      s = s + 32'(av * bv);
    end
    return s;
  endfunction

  // monitor: compare each write with the scoreboard head
  always @(negedge clk) begin
    if (rstN && cWrEn) begin
      if (expQ.size() == 0) begin
        check(0, "R6/R7", "unexpected write", cWrData, 32'h0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(int'(rowIdx) == it.row && int'(colIdx) == it.col, "R4",
              "write order row/col", {rowIdx, 12'h0, colIdx},
              32'(it.row * 65536 + it.col));
        check(cWrData == it.value, it.req, "element value", cWrData, it.value);
      end
      cMem[rowIdx][colIdx] = cWrData;
    end
  end

  task automatic fillRandom();
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 64; c++) begin
        aMem[r][c] = nextRand() >> 16;
        bMem[r][c] = nextRand() >> 16;
      end
      for (int c = 0; c < 16; c++) cMem[r][c] = nextRand();
    end
  endtask

  // driver: queue expected items, start, time the run
  task automatic runOp(logic [1:0] md, int m, int n, int k, string req, bit pokeStart);
    int cnt;
    for (int r = 0; r < m; r++)
      for (int c = 0; c < n; c++) begin
        item_t it;
        it.row = r; it.col = c; it.value = refElem(r, c, k, md); it.req = req;
        expQ.push_back(it);
      end
    @(negedge clk);
    mode = md; dimM = 5'(m); dimN = 5'(n); dimK = 7'(k); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R5", "busy after start", 32'(busy), 32'd1);
    cnt = 0;
    while (cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (pokeStart && cnt == 2) begin
        start = 1'b1; dimM = 5'd1; dimN = 5'd1; dimK = 7'd4; mode = ~md;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    check(cnt == m * n * (k / 4), "R5", "cycles start to done", 32'(cnt), 32'(m * n * (k / 4)));
    check(busy == 1'b0, "R5", "busy low with done", 32'(busy), 32'd0);
    check(expQ.size() == 0, "R4", "all elements written", 32'(expQ.size()), 32'd0);
    @(negedge clk);
    check(done == 1'b0, "R5", "done single pulse", 32'(done), 32'd0);
  endtask

  task automatic badOp(int m, int n, int k);
    @(negedge clk);
    dimM = 5'(m); dimN = 5'(n); dimK = 7'(k); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, "R6", "err on bad shape", 32'(err), 32'd1);
    check(busy == 1'b0, "R6", "busy stays low", 32'(busy), 32'd0);
    @(negedge clk);
    check(err == 1'b0, "R6", "err single pulse", 32'(err), 32'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
        finish();
      end
    end
  end

  initial begin
    logic [31:0] saved;
    fillRandom();
    repeat (3) @(negedge clk);
    // R8: reset state
    check({busy, done, err, cWrEn} == 4'b0, "R8", "reset outputs",
          {28'h0, busy, done, err, cWrEn}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: signed x signed on a mid-size shape
    runOp(2'd3, 3, 4, 16, "R1", 0);
    // R2: the three other modes
    runOp(2'd0, 2, 3, 8, "R2", 0);
    runOp(2'd1, 4, 2, 12, "R2", 0);
    runOp(2'd2, 2, 5, 20, "R2", 0);
    // R4: single-group single-element boundary
    runOp(2'd3, 1, 1, 4, "R4", 0);
    // R3: wraparound with extreme bytes
    for (int i = 0; i < 4; i++) begin aMem[0][i] = 8'h7F; bMem[0][i] = 8'h7F; end
    cMem[0][0] = 32'h7FFF_FFFF;
    runOp(2'd3, 1, 1, 4, "R3", 0);
    for (int i = 0; i < 4; i++) begin aMem[0][i] = 8'hFF; bMem[0][i] = 8'hFF; end
    cMem[0][0] = 32'hFFFF_FFFF;
    runOp(2'd0, 1, 1, 4, "R3", 0);
    for (int i = 0; i < 4; i++) begin aMem[0][i] = 8'h80; bMem[0][i] = 8'hFF; end
    runOp(2'd2, 1, 1, 4, "R3", 0);
    runOp(2'd1, 1, 1, 4, "R3", 0);
    // R7: start pulse during a run is ignored
    fillRandom();
    runOp(2'd1, 3, 3, 12, "R7", 1);
    // R6: rejected shapes, accumulator untouched
    saved = cMem[0][0];
    badOp(1, 1, 6);
    badOp(0, 1, 4);
    badOp(1, 0, 4);
    badOp(17, 1, 4);
    badOp(1, 17, 4);
    badOp(1, 1, 68);
    badOp(1, 1, 0);
    check(cMem[0][0] == saved, "R6", "accumulator unchanged", cMem[0][0], saved);
    // R4: full-size operation
    runOp(2'd3, 16, 16, 64, "R4", 0);
    // R3: accumulate twice into the same tile
    runOp(2'd0, 2, 2, 8, "R3", 0);
    runOp(2'd0, 2, 2, 8, "R3", 0);
    finish();
  end
endmodule